// File: doc/BRIEF.md
# Fixed-Point Interval Arithmetic Datapath

This block evaluates one interval operation per accepted request. Two signed intervals X = [xl, xu] and Y = [yl, yu] arrive as 16-bit two's complement Q7.8 values with a 2-bit opcode. The block returns a 32-bit lower and a 32-bit upper endpoint such that every point-wise result drawn from the operand intervals lies between them. The supported operations are addition, subtraction, multiplication and division by a power of two done as a shift. Division by zero therefore cannot be requested.

The lower and upper endpoints come from two separate paths. Each path raises its own overflow flag. A shared command stage sorts each operand interval into negative, zero-straddling or positive. It then tells each path which endpoint product to form for a multiply. A disjoint flag reports that the two operand intervals share no point. Narrowing to 16 bits, block exponents and rescaling happen downstream. Results are registered once and qualified by a valid strobe.

Top module: `ia_datapath`

## Requirements
- R1: With op_i = 2'b00 (add), lo_o is XL+YL and hi_o is XU+YU, each sign-extended to 32 bits with 8 fraction bits.
- R2: With op_i = 2'b01 (subtract), lo_o is XL-YU and hi_o is XU-YL, sign-extended to 32 bits.
- R3: For add and subtract, ovf_lo_o (or ovf_hi_o) is high exactly when that endpoint's exact result lies outside -32768..32767. The flags are independent of each other, and the 32-bit endpoint still carries the exact result.
- R4: With op_i = 2'b10 (multiply), lo_o and hi_o are the minimum and the maximum of the four endpoint products, as 32-bit values with 16 fraction bits, for every combination of negative, straddling and positive operand intervals.
- R5: When both operand intervals straddle zero, the multiply gives lo_o = min(XL*YU, XU*YL) and hi_o = max(XL*YL, XU*YU). This includes the full-range extreme -32768 and 32767.
- R6: Multiply and shift operations never raise ovf_lo_o or ovf_hi_o.
- R7: With op_i = 2'b11 (divide by 2^k, k = shamt_i in 0..15), lo_o is XL/2^k rounded toward minus infinity and hi_o is XU/2^k rounded toward plus infinity. With k = 0 the operand endpoints pass through unchanged.
- R8: disjoint_o is high exactly when YU < XL or XU < YL, for every opcode.
- R9: valid_o follows valid_i one clock later. Results and flags load only on a cycle with valid_i high and hold their values otherwise.
- R10: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 00 add, 01 subtract, 10 multiply, 11 shift divide |
| shamt_i | input | 4 | Power-of-two exponent for divide |
| xl_i | input | 16 | X lower endpoint, Q7.8 |
| xu_i | input | 16 | X upper endpoint, Q7.8 |
| yl_i | input | 16 | Y lower endpoint, Q7.8 |
| yu_i | input | 16 | Y upper endpoint, Q7.8 |
| valid_o | output | 1 | Result strobe |
| lo_o | output | 32 | Result lower endpoint |
| hi_o | output | 32 | Result upper endpoint |
| ovf_lo_o | output | 1 | Lower endpoint left 16-bit range |
| ovf_hi_o | output | 1 | Upper endpoint left 16-bit range |
| disjoint_o | output | 1 | Operand intervals do not intersect |

## Verification
Overflow on one endpoint path and the disjoint detection can occur in the same result. The bench provokes this with an add of X = [-32768, -32512] and Y = [-10, 100]. The lower sum falls below the 16-bit range, the upper sum does not, and X lies wholly below Y. The result passes only if ovf_lo_o and disjoint_o are high together, ovf_hi_o stays low, and both endpoints hold the exact sums.

// File: rtl/ia_pkg.sv
package ia_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'b00, OP_SUB = 2'b01, OP_MUL = 2'b10, OP_SHR = 2'b11} op_e;
  typedef enum logic [1:0] {CL_NEG = 2'b00, CL_MIX = 2'b01, CL_POS = 2'b10} cls_e;
  // x_hi/y_hi pick endpoints for the primary product; dual adds the swapped pair
  typedef struct packed {
    logic x_hi;
    logic y_hi;
    logic dual;
  } mul_cmd_t;
endpackage

// File: rtl/ia_flag_gen.sv
module ia_flag_gen
  import ia_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] xl_i,
  input  logic signed [DW-1:0] xu_i,
  input  logic signed [DW-1:0] yl_i,
  input  logic signed [DW-1:0] yu_i,
  output mul_cmd_t             cmd_lo_o,
  output mul_cmd_t             cmd_hi_o,
  output logic                 disjoint_o
);
  cls_e xc, yc;

  function automatic cls_e classify(logic signed [DW-1:0] lo, logic signed [DW-1:0] hi);
    if (hi[DW-1])      return CL_NEG;
    else if (!lo[DW-1]) return CL_POS;
    else               return CL_MIX;
  endfunction

  function automatic mul_cmd_t mk(logic x, logic y, logic d);
    mul_cmd_t c;
    c.x_hi = x;
    c.y_hi = y;
    c.dual = d;
    return c;
  endfunction

  assign xc = classify(xl_i, xu_i);
  assign yc = classify(yl_i, yu_i);

  always_comb begin
    case ({xc, yc})
      {CL_POS, CL_POS}: begin cmd_lo_o = mk(1'b0, 1'b0, 1'b0); cmd_hi_o = mk(1'b1, 1'b1, 1'b0); end
      {CL_POS, CL_MIX}: begin cmd_lo_o = mk(1'b1, 1'b0, 1'b0); cmd_hi_o = mk(1'b1, 1'b1, 1'b0); end
      {CL_POS, CL_NEG}: begin cmd_lo_o = mk(1'b1, 1'b0, 1'b0); cmd_hi_o = mk(1'b0, 1'b1, 1'b0); end
      {CL_MIX, CL_POS}: begin cmd_lo_o = mk(1'b0, 1'b1, 1'b0); cmd_hi_o = mk(1'b1, 1'b1, 1'b0); end
      {CL_MIX, CL_NEG}: begin cmd_lo_o = mk(1'b1, 1'b0, 1'b0); cmd_hi_o = mk(1'b0, 1'b0, 1'b0); end
      {CL_NEG, CL_POS}: begin cmd_lo_o = mk(1'b0, 1'b1, 1'b0); cmd_hi_o = mk(1'b1, 1'b0, 1'b0); end
      {CL_NEG, CL_MIX}: begin cmd_lo_o = mk(1'b0, 1'b1, 1'b0); cmd_hi_o = mk(1'b0, 1'b0, 1'b0); end
      {CL_NEG, CL_NEG}: begin cmd_lo_o = mk(1'b1, 1'b1, 1'b0); cmd_hi_o = mk(1'b0, 1'b0, 1'b0); end
      // both straddle zero: compare two candidates per endpoint
      default:          begin cmd_lo_o = mk(1'b0, 1'b1, 1'b1); cmd_hi_o = mk(1'b0, 1'b0, 1'b1); end
    endcase
  end

  assign disjoint_o = (yu_i < xl_i) || (xu_i < yl_i);
endmodule

// File: rtl/ia_bound_path.sv
module ia_bound_path
  import ia_pkg::*;
#(
  parameter  int DW    = 16,
  parameter  int UPPER = 0,
  localparam int RW    = 2 * DW,
  localparam int SW    = $clog2(DW)
) (
  input  op_e                  op_i,
  input  mul_cmd_t             cmd_i,
  input  logic [SW-1:0]        shamt_i,
  input  logic signed [DW-1:0] xl_i,
  input  logic signed [DW-1:0] xu_i,
  input  logic signed [DW-1:0] yl_i,
  input  logic signed [DW-1:0] yu_i,
  output logic signed [RW-1:0] res_o,
  output logic                 ovf_o
);
  logic signed [DW-1:0] self_x, add_y, sub_y;
  logic signed [DW:0]   sum_add, sum_sub;
  logic signed [RW-1:0] xa, ya, xb, yb, m0, m1, m_sel;
  logic signed [RW-1:0] ext, bias, shr;

  generate
    if (UPPER != 0) begin : g_hi
      assign self_x = xu_i;
      assign add_y  = yu_i;
      assign sub_y  = yl_i;
      assign m_sel  = (cmd_i.dual && (m1 > m0)) ? m1 : m0;
      assign bias   = (RW'(1) << shamt_i) - RW'(1);
    end else begin : g_lo
      assign self_x = xl_i;
      assign add_y  = yl_i;
      assign sub_y  = yu_i;
      assign m_sel  = (cmd_i.dual && (m1 < m0)) ? m1 : m0;
      assign bias   = '0;
    end
  endgenerate

  assign sum_add = {self_x[DW-1], self_x} + {add_y[DW-1], add_y};
  assign sum_sub = {self_x[DW-1], self_x} - {sub_y[DW-1], sub_y};

  // primary pair from command, secondary pair is the swapped endpoints
  assign xa = RW'(cmd_i.x_hi ? xu_i : xl_i);
  assign ya = RW'(cmd_i.y_hi ? yu_i : yl_i);
  assign xb = RW'(cmd_i.x_hi ? xl_i : xu_i);
  assign yb = RW'(cmd_i.y_hi ? yl_i : yu_i);
  assign m0 = xa * ya;
  assign m1 = xb * yb;

  // upper path adds 2^k-1 before shifting to round outward
  assign ext = RW'(self_x);
  assign shr = (ext + bias) >>> shamt_i;

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    case (op_i)
      OP_ADD: begin res_o = RW'(sum_add); ovf_o = sum_add[DW] ^ sum_add[DW-1]; end
      OP_SUB: begin res_o = RW'(sum_sub); ovf_o = sum_sub[DW] ^ sum_sub[DW-1]; end
      OP_MUL: res_o = m_sel;
      default: res_o = shr;
    endcase
  end
endmodule

// File: rtl/ia_datapath.sv
module ia_datapath
  import ia_pkg::*;
#(
  parameter  int DW = 16,
  localparam int RW = 2 * DW,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    op_i,
  input  logic [SW-1:0] shamt_i,
  input  logic [DW-1:0] xl_i,
  input  logic [DW-1:0] xu_i,
  input  logic [DW-1:0] yl_i,
  input  logic [DW-1:0] yu_i,
  output logic          valid_o,
  output logic [RW-1:0] lo_o,
  output logic [RW-1:0] hi_o,
  output logic          ovf_lo_o,
  output logic          ovf_hi_o,
  output logic          disjoint_o
);
  mul_cmd_t             cmd [2];
  logic signed [RW-1:0] res [2];
  logic                 ovf [2];
  logic                 disj;
  op_e                  op;

  assign op = op_e'(op_i);

  ia_flag_gen #(.DW(DW)) u_flag (
    .xl_i       (xl_i),
    .xu_i       (xu_i),
    .yl_i       (yl_i),
    .yu_i       (yu_i),
    .cmd_lo_o   (cmd[0]),
    .cmd_hi_o   (cmd[1]),
    .disjoint_o (disj)
  );

  for (genvar g = 0; g < 2; g++) begin : g_path
    ia_bound_path #(.DW(DW), .UPPER(g)) u_path (
      .op_i    (op),
      .cmd_i   (cmd[g]),
      .shamt_i (shamt_i),
      .xl_i    (xl_i),
      .xu_i    (xu_i),
      .yl_i    (yl_i),
      .yu_i    (yu_i),
      .res_o   (res[g]),
      .ovf_o   (ovf[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      lo_o       <= '0;
      hi_o       <= '0;
      ovf_lo_o   <= 1'b0;
      ovf_hi_o   <= 1'b0;
      disjoint_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        lo_o       <= res[0];
        hi_o       <= res[1];
        ovf_lo_o   <= ovf[0];
        ovf_hi_o   <= ovf[1];
        disjoint_o <= disj;
      end
    end
  end
endmodule

// File: rtl/ia_datapath_chk.sv
module ia_datapath_chk #(
  parameter  int DW = 16,
  localparam int RW = 2 * DW,
  localparam int SW = $clog2(DW)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [1:0]    op_i,
  input logic [SW-1:0] shamt_i,
  input logic [DW-1:0] xl_i,
  input logic [DW-1:0] xu_i,
  input logic [DW-1:0] yl_i,
  input logic [DW-1:0] yu_i,
  input logic          valid_o,
  input logic [RW-1:0] lo_o,
  input logic [RW-1:0] hi_o,
  input logic          ovf_lo_o,
  input logic          ovf_hi_o,
  input logic          disjoint_o
);
  logic signed [DW:0] add_l, add_u, sub_l, sub_u;
  logic               well_formed, apart;

  assign add_l = $signed(xl_i) + $signed(yl_i);
  assign add_u = $signed(xu_i) + $signed(yu_i);
  assign sub_l = $signed(xl_i) - $signed(yu_i);
  assign sub_u = $signed(xu_i) - $signed(yl_i);
  assign well_formed = ($signed(xl_i) <= $signed(xu_i)) && ($signed(yl_i) <= $signed(yu_i));
  assign apart = ($signed(yu_i) < $signed(xl_i)) || ($signed(xu_i) < $signed(yl_i));

  AST_ADD_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b00 |=> $signed(lo_o) == $past(add_l) && $signed(hi_o) == $past(add_u)); // R1
  AST_SUB_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b01 |=> $signed(lo_o) == $past(sub_l) && $signed(hi_o) == $past(sub_u)); // R2
  AST_ORDERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && well_formed |=> $signed(lo_o) <= $signed(hi_o)); // R4
  AST_NO_OVF_MUL_SHR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[1] |=> !ovf_lo_o && !ovf_hi_o); // R6
  AST_SHR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b11 && shamt_i == '0 |=>
      $signed(lo_o) == $signed($past(xl_i)) && $signed(hi_o) == $signed($past(xu_i))); // R7
  AST_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> disjoint_o == $past(apart)); // R8
  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(lo_o) && $stable(hi_o) && $stable(disjoint_o)); // R9
endmodule

bind ia_datapath ia_datapath_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_ia_datapath.sv
`timescale 1ns/1ps
module sim_ia_datapath;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [3:0]  shamt_i = '0;
  logic [15:0] xl_i = '0, xu_i = '0, yl_i = '0, yu_i = '0;
  logic        valid_o, ovf_lo_o, ovf_hi_o, disjoint_o;
  logic [31:0] lo_o, hi_o;

  int n_cmp = 0;
  int n_bad = 0;
  int e_lo, e_hi;
  bit e_ol, e_oh, e_dj;

  always #5 clk_i = ~clk_i;

  ia_datapath u0 (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d (0x%08h) expected %0d (0x%08h)",
               req, what, $signed(act), act, $signed(exp), exp);
    end
  endtask

  // independent model of the requirements
  task automatic model(int op, int xl, int xu, int yl, int yu, int k);
    int p[4];
    e_ol = 0; e_oh = 0;
    case (op)
      0: begin e_lo = xl + yl; e_hi = xu + yu; end
      1: begin e_lo = xl - yu; e_hi = xu - yl; end
      2: begin
        p[0] = xl * yl; p[1] = xl * yu; p[2] = xu * yl; p[3] = xu * yu;
        e_lo = p[0]; e_hi = p[0];
        for (int i = 1; i < 4; i++) begin
          if (p[i] < e_lo) e_lo = p[i];
          if (p[i] > e_hi) e_hi = p[i];
        end
      end
      default: begin e_lo = xl >>> k; e_hi = -((-xu) >>> k); end
    endcase
    if (op < 2) begin
      e_ol = (e_lo > 32767) || (e_lo < -32768);
      e_oh = (e_hi > 32767) || (e_hi < -32768);
    end
    e_dj = (yu < xl) || (xu < yl);
  endtask

  task automatic do_op(int op, int xl, int xu, int yl, int yu, int k, string req);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op[1:0]; shamt_i = k[3:0];
    xl_i = xl[15:0]; xu_i = xu[15:0]; yl_i = yl[15:0]; yu_i = yu[15:0];
    @(negedge clk_i);
    valid_i = 1'b0;
    model(op, xl, xu, yl, yu, k);
    check(req, "lo_o", lo_o, e_lo);
    check(req, "hi_o", hi_o, e_hi);
    check(op < 2 ? "R3" : "R6", "ovf_lo_o", {31'b0, ovf_lo_o}, {31'b0, e_ol});
    check(op < 2 ? "R3" : "R6", "ovf_hi_o", {31'b0, ovf_hi_o}, {31'b0, e_oh});
    check("R8", "disjoint_o", {31'b0, disjoint_o}, {31'b0, e_dj});
    check("R9", "valid_o", {31'b0, valid_o}, 32'd1);
  endtask

  task automatic t_reset();
    check("R10", "lo_o", lo_o, 0);
    check("R10", "hi_o", hi_o, 0);
    check("R10", "flags", {27'b0, valid_o, ovf_lo_o, ovf_hi_o, disjoint_o}, 0);
  endtask

  task automatic t_add_sub();
    do_op(0, 256, 512, 768, 1024, 0, "R1");       // [1,2]+[3,4] = [4,6]
    do_op(0, -1000, 300, -5, 7, 0, "R1");
    do_op(1, 256, 512, 768, 1024, 0, "R2");       // [1,2]-[3,4] = [-3,-1]
    do_op(1, -700, -20, -900, 50, 0, "R2");
  endtask

  task automatic t_overflow();
    do_op(0, 100, 32767, 0, 1, 0, "R3");          // upper only
    do_op(1, -32768, 0, 0, 1, 0, "R3");           // lower only via subtract
    do_op(1, -32768, 32767, -32768, 32767, 0, "R3"); // both
    // lower overflow together with disjoint, upper clean
    do_op(0, -32768, -32512, -10, 100, 0, "R3");
    check("R3", "concurrent ovf_lo/disjoint", {30'b0, ovf_lo_o, disjoint_o}, 32'd3);
  endtask

  task automatic t_mul_cases();
    int il[3] = '{-768, -512, 512};
    int iu[3] = '{-512, 768, 1024};
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        do_op(2, il[i], iu[i], il[j], iu[j], 0, "R4");
    do_op(2, 0, 0, -300, 200, 0, "R4");
  endtask

  task automatic t_mul_straddle();
    do_op(2, -300, 200, -100, 500, 0, "R5");
    do_op(2, -32768, 32767, -32768, 32767, 0, "R5");
    do_op(2, -32768, -32768, -32768, -32768, 0, "R4");
  endtask

  task automatic t_shift();
    do_op(3, -100, 100, 0, 0, 0, "R7");
    do_op(3, -100, 100, 0, 0, 4, "R7");           // [-7, 7]
    do_op(3, -32768, 1, 5, 9, 15, "R7");          // [-1, 1]
    do_op(3, 48, 64, 0, 0, 4, "R7");              // exact: [3, 4]
  endtask

  task automatic t_hold();
    logic [31:0] lo_s, hi_s;
    do_op(0, 10, 20, 30, 40, 0, "R9");
    lo_s = lo_o; hi_s = hi_o;
    @(negedge clk_i);
    op_i = 2'b10; xl_i = 16'h8000; xu_i = 16'h7fff; yl_i = 16'h8000; yu_i = 16'h7fff;
    @(negedge clk_i);
    check("R9", "hold lo_o", lo_o, lo_s);
    check("R9", "hold hi_o", hi_o, hi_s);
    check("R9", "idle valid_o", {31'b0, valid_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_add_sub();
    t_overflow();
    t_mul_cases();
    t_mul_straddle();
    t_shift();
    t_hold();
    repeat (2) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule